// File: doc/BRIEF.md
# Serial Multichannel Converter Frame Master

This block is the serial-port master for a 16-bit multichannel converter run in external-clock conversion mode. A host hands it one request at a time over a valid/ready handshake. A request either writes a 4-bit mode/range setting for one channel or starts a conversion on one channel. For each request the block pulls chip select low and sends a command byte on the data-out line, most significant bit first.

A configuration request is an 8-clock frame. A conversion request is a 32-clock frame. The serial clock runs without pause for the whole frame, because the converter's track-and-hold follows it. During the last 16 clocks of a conversion the block shifts in the result. After chip select has risen and the guard gap has passed, it shows the result with a one-cycle valid strobe and the channel number.

The serial clock is made from the system clock. Its half-period is set by a host value that the block latches when it accepts a request. The block also keeps a copy of the last setting written to each channel, which the host can read back at any time.

Top module: `adc_serial_master`

## Requirements
- R1: After a synchronous active-low reset, `spi_cs_n` is 1, `spi_sclk` is 0, `req_ready` is 1, `res_valid` is 0, and every channel's stored setting reads back as 0.
- R2: A conversion frame sends the command byte {1, chan[2:0], 0000} on `spi_mosi`, MSB first. Each bit is stable at the rising edge of `spi_sclk` that samples it.
- R3: A conversion frame has exactly 32 rising edges of `spi_sclk` while `spi_cs_n` is low. `spi_mosi` is 0 for every bit after the command byte.
- R4: A configuration frame sends {1, chan[2:0], cfg[3:0]} MSB first. It has exactly 8 rising edges and produces no `res_valid` pulse.
- R5: The result is made of the `spi_miso` values sampled at rising edges 17 to 32 of a conversion frame, the first of them as bit 15. `spi_miso` at any other edge has no effect on `res_data`.
- R6: Each conversion gives exactly one `res_valid` pulse, one cycle long. It comes after `spi_cs_n` has risen, and `res_chan` carries that request's channel.
- R7: `spi_sclk` stays high and stays low for exactly `half_div`+1 system clocks, using the `half_div` value latched at acceptance. `spi_sclk` is 0 whenever `spi_cs_n` is 1.
- R8: Between two frames, `spi_cs_n` stays high for at least 2*(`half_div`+1) system clocks.
- R9: A request is accepted only on a cycle where both `req_valid` and `req_ready` are 1. `req_ready` is 0 from the cycle after acceptance until the frame has finished. Requests presented while busy start no frame and change no stored setting.
- R10: `cfg_rd_nib` returns the `cfg` of the last configuration request accepted for channel `cfg_rd_chan`. Conversion requests leave the stored settings unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_div | input | 8 | Serial clock half-period minus one, in system clocks |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 1 | 0 = conversion, 1 = configuration write |
| req_chan | input | 3 | Channel number |
| req_cfg | input | 4 | Mode/range setting for a configuration write |
| res_valid | output | 1 | One-cycle strobe for a finished conversion |
| res_data | output | 16 | Conversion result |
| res_chan | output | 3 | Channel the result belongs to |
| cfg_rd_chan | input | 3 | Channel whose stored setting is read back |
| cfg_rd_nib | output | 4 | Stored setting of `cfg_rd_chan` |
| spi_cs_n | output | 1 | Converter chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Command data to the converter |
| spi_miso | input | 1 | Result data from the converter |

## Verification
A conversion accepted at edge A lowers chip select at A and raises the first serial clock at A+(`half_div`+1). Chip select rises 64·(`half_div`+1) clocks after A, and `res_valid` and `req_ready` appear together 2·(`half_div`+1) clocks after that. The bench does not predict that exact cycle. It polls on falling system-clock edges until `req_ready` returns, and it records any `res_valid` it sees along the way, so a pulse one cycle early or late is still counted. Serial-side results are checked by a converter model that reacts to the serial clock and chip-select edges: it counts edges, captures the command and drives result bits. A readback is combinational and is compared on the falling edge after the request that wrote it has finished.

// File: rtl/adcm_pkg.sv
// Package: shared constants and types for the serial converter frame master.
// Assumes a converter frame of command byte, filler byte, then a 16-bit result.
package adcm_pkg;
    localparam int CMD_W      = 8;
    localparam int CFG_W      = 4;
    localparam int RES_W      = 16;
    localparam int FRAME_CONV = 32;
    localparam int RES_START  = FRAME_CONV - RES_W;

    typedef enum logic {
        OP_CONVERT = 1'b0,
        OP_CONFIG  = 1'b1
    } op_e;
endpackage

// File: rtl/adcm_half_timer.sv
// Module: half-period timer. While enabled it pulses tick once every
// (half_div+1) clocks. It restarts from zero whenever it is disabled.
// Assumes half_div is held stable while enabled.
module adcm_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = en && (cnt == half_div);

    // Count clocks within the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!en || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // R7: the counter never passes the half-period limit
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt <= half_div));
endmodule

// File: rtl/adcm_frame_engine.sv
// Module: serial frame engine. It runs one chip-select frame of 8 or 32
// serial clocks. DIN changes on the falling edge and DOUT is sampled on
// the rising edge. The result is taken only in the last RES_W clocks of a
// conversion, and a two-half-period gap with chip select high follows
// every frame. Assumes start is raised only while busy is low.
module adcm_frame_engine
    import adcm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_conv,
    input  logic [CMD_W-1:0] cmd,
    input  logic [DIV_W-1:0] half_div,
    input  logic             miso,
    output logic             cs_n,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [RES_W-1:0] result
);
    localparam int CNT_W = $clog2(FRAME_CONV + 1);

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_GAP} st_e;

    st_e              state;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] frame_len;
    logic [CMD_W-1:0] tx;
    logic [DIV_W-1:0] hd_q;
    logic             gap_half;
    logic             tick;

    adcm_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (state != S_IDLE),
        .half_div (hd_q),
        .tick     (tick)
    );

    assign mosi = tx[CMD_W-1];
    assign busy = (state != S_IDLE);

    // Frame sequencing, bit shifting and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            bit_cnt   <= '0;
            frame_len <= '0;
            tx        <= '0;
            hd_q      <= '0;
            gap_half  <= 1'b0;
            cs_n      <= 1'b1;
            sclk      <= 1'b0;
            done      <= 1'b0;
            result    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state     <= S_RUN;
                        tx        <= cmd;
                        hd_q      <= half_div;
                        bit_cnt   <= '0;
                        frame_len <= is_conv ? CNT_W'(FRAME_CONV) : CNT_W'(CMD_W);
                        cs_n      <= 1'b0;
                        sclk      <= 1'b0;
                    end
                end
                S_RUN: begin
                    if (tick) begin
                        if (!sclk) begin
                            sclk    <= 1'b1;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt >= CNT_W'(RES_START))
                                result <= {result[RES_W-2:0], miso};
                        end else begin
                            sclk <= 1'b0;
                            if (bit_cnt == frame_len) begin
                                state    <= S_GAP;
                                cs_n     <= 1'b1;
                                tx       <= '0;
                                gap_half <= 1'b0;
                            end else begin
                                tx <= {tx[CMD_W-2:0], 1'b0};
                            end
                        end
                    end
                end
                S_GAP: begin
                    if (tick) begin
                        if (gap_half) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else begin
                            gap_half <= 1'b1;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R3: a frame never has more rising edges than its length
    assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN) |-> (bit_cnt <= frame_len));
    // R7: the serial clock rests low outside the running phase
    assert_sclk_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_RUN) |-> !sclk);
    // R8: chip select stays high throughout the guard gap
    assert_gap_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP) |-> cs_n);
endmodule

// File: rtl/adcm_cfg_shadow.sv
// Module: per-channel copy of the last setting written. There is one write
// port and one combinational read port. Assumes wr_chan < CHANNELS.
module adcm_cfg_shadow #(
    parameter int CHANNELS = 8,
    parameter int CFG_W    = 4,
    localparam int CH_W    = $clog2(CHANNELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [CFG_W-1:0] wr_nib,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [CFG_W-1:0] rd_nib
);
    logic [CFG_W-1:0] regs [CHANNELS];

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        // Hold one channel's setting, replaced on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && (wr_chan == CH_W'(i)))
                regs[i] <= wr_nib;
        end

        // R10: a channel's setting changes only through a write to it
        assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && (wr_chan == CH_W'(i))) |=> $stable(regs[i]));
    end

    assign rd_nib = regs[rd_chan];
endmodule

// File: rtl/adc_serial_master.sv
// Module: top of the serial converter frame master. It accepts host
// requests, builds the command byte, starts a frame, tags each result with
// its channel and keeps the per-channel setting copy. Assumes the host
// holds half_div stable during the acceptance cycle.
module adc_serial_master
    import adcm_pkg::*;
#(
    parameter int CHANNELS = 8,
    parameter int DIV_W    = 8,
    localparam int CH_W    = $clog2(CHANNELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_op,
    input  logic [CH_W-1:0]  req_chan,
    input  logic [CFG_W-1:0] req_cfg,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic [CH_W-1:0]  res_chan,
    input  logic [CH_W-1:0]  cfg_rd_chan,
    output logic [CFG_W-1:0] cfg_rd_nib,
    output logic             spi_cs_n,
    output logic             spi_sclk,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    logic             accept;
    logic             is_conv;
    logic             busy;
    logic             done;
    logic             conv_q;
    logic [CMD_W-1:0] cmd;

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign is_conv   = (op_e'(req_op) == OP_CONVERT);
    assign cmd       = {1'b1, req_chan, (is_conv ? {CFG_W{1'b0}} : req_cfg)};

    // Remember the kind and channel of the frame in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_q   <= 1'b0;
            res_chan <= '0;
        end else if (accept) begin
            conv_q   <= is_conv;
            res_chan <= req_chan;
        end
    end

    assign res_valid = done && conv_q;

    adcm_frame_engine #(.DIV_W(DIV_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .is_conv  (is_conv),
        .cmd      (cmd),
        .half_div (half_div),
        .miso     (spi_miso),
        .cs_n     (spi_cs_n),
        .sclk     (spi_sclk),
        .mosi     (spi_mosi),
        .busy     (busy),
        .done     (done),
        .result   (res_data)
    );

    adcm_cfg_shadow #(.CHANNELS(CHANNELS), .CFG_W(CFG_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept && !is_conv),
        .wr_chan (req_chan),
        .wr_nib  (req_cfg),
        .rd_chan (cfg_rd_chan),
        .rd_nib  (cfg_rd_nib)
    );

    // R6: the result strobe lasts a single cycle
    assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R9: an accepted request makes the block busy on the next cycle
    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    // R7: no serial clock pulse while chip select is high
    assert_sclk_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
endmodule

// File: tb/adc_serial_master_bench.sv
// Bench: a converter-port model plus random and directed requests, with
// expected values computed by bench functions.
module adc_serial_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] half_div = 8'd0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_op = 1'b0;
    logic [2:0] req_chan = 3'd0;
    logic [3:0] req_cfg = 4'd0;
    logic       res_valid;
    logic [15:0] res_data;
    logic [2:0] res_chan;
    logic [2:0] cfg_rd_chan = 3'd0;
    logic [3:0] cfg_rd_nib;
    logic       spi_cs_n;
    logic       spi_sclk;
    logic       spi_mosi;
    logic       spi_miso = 1'b1;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    adc_serial_master u_adc_serial_master (
        .clk(clk), .rst_n(rst_n), .half_div(half_div),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_chan(req_chan), .req_cfg(req_cfg),
        .res_valid(res_valid), .res_data(res_data), .res_chan(res_chan),
        .cfg_rd_chan(cfg_rd_chan), .cfg_rd_nib(cfg_rd_nib),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Converter model state.
    logic [15:0] pat = 16'h0;
    int          rises = 0;
    logic [7:0]  cmd_cap = 8'h0;
    logic        tail_nz = 1'b0;
    int          frames = 0;
    int          last_rises = 0;
    int          hi_cnt = 0;
    int          lo_cnt = 0;
    logic        bad_half = 1'b0;
    int          gap_cnt = 0;
    int          last_gap = 1000000;
    logic        sclk_in_idle = 1'b0;
    int          cur_hd = 0;

    logic [3:0]  exp_cfg [8];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_cmd(input bit conv, input logic [2:0] ch,
                                           input logic [3:0] nib);
        return {1'b1, ch, conv ? 4'b0000 : nib};
    endfunction

    always @(negedge spi_cs_n) begin
        rises = 0; cmd_cap = 8'h0; tail_nz = 1'b0; bad_half = 1'b0;
        last_gap = gap_cnt;
    end
    always @(posedge spi_cs_n) begin
        frames++; last_rises = rises; gap_cnt = 0; spi_miso = 1'b1;
    end
    always @(posedge spi_sclk) begin
        if (!spi_cs_n) begin
            if (rises < 8) cmd_cap = {cmd_cap[6:0], spi_mosi};
            else if (spi_mosi) tail_nz = 1'b1;
            if (rises > 0 && lo_cnt != cur_hd + 1) bad_half = 1'b1;
            rises++;
        end
        hi_cnt = 0;
    end
    always @(negedge spi_sclk) begin
        if (hi_cnt != cur_hd + 1) bad_half = 1'b1;
        lo_cnt = 0;
        if (!spi_cs_n)
            spi_miso = (rises >= 16 && rises <= 31) ? pat[31 - rises] : 1'b1;
    end
    always @(negedge clk) begin
        cycles++;
        if (spi_sclk) hi_cnt++; else lo_cnt++;
        if (spi_cs_n) gap_cnt++;
        if (spi_cs_n && spi_sclk && rst_n) sclk_in_idle = 1'b1;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog R9 actual=%0d expected=<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_txn(input bit conv, input logic [2:0] ch, input logic [3:0] nib,
                           input logic [7:0] hd, input logic [15:0] p, input bit poke);
        int n_valid = 0;
        logic [15:0] got = 16'h0;
        logic [2:0] got_ch = 3'd0;
        int f0;
        int prev_hd = cur_hd;
        int wait_cyc = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        pat = p; half_div = hd;
        req_valid = 1'b1; req_op = conv ? 1'b0 : 1'b1; req_chan = ch; req_cfg = nib;
        f0 = frames;
        @(posedge clk);
        cur_hd = int'(hd);
        @(negedge clk);
        chk(!req_ready, "R9", "ready after accept", req_ready, 0);
        if (poke) begin
            req_op = 1'b1; req_chan = 3'd5; req_cfg = ~exp_cfg[5];
        end else req_valid = 1'b0;
        while (!req_ready && wait_cyc < 4000) begin
            if (poke && wait_cyc == 10) req_valid = 1'b0;
            @(negedge clk);
            wait_cyc++;
            if (res_valid) begin n_valid++; got = res_data; got_ch = res_chan; end
        end
        req_valid = 1'b0;
        if (!conv) exp_cfg[ch] = nib;
        chk(frames == f0 + 1, "R9", "frames per request", frames - f0, 1);
        chk(cmd_cap == exp_cmd(conv, ch, nib), conv ? "R2" : "R4", "command byte",
            cmd_cap, exp_cmd(conv, ch, nib));
        chk(last_rises == (conv ? 32 : 8), conv ? "R3" : "R4", "frame clocks",
            last_rises, conv ? 32 : 8);
        chk(!bad_half, "R7", "sclk half period", bad_half, 0);
        if (f0 > 0)
            chk(last_gap >= 2 * (prev_hd + 1), "R8", "cs high gap", last_gap, 2 * (prev_hd + 1));
        if (conv) begin
            chk(!tail_nz, "R3", "mosi after command", tail_nz, 0);
            chk(n_valid == 1, "R6", "valid pulses", n_valid, 1);
            chk(got == p, "R5", "result", got, p);
            chk(got_ch == ch, "R6", "result channel", got_ch, ch);
        end else begin
            chk(n_valid == 0, "R4", "valid pulses on config", n_valid, 0);
        end
    endtask

    task automatic check_readback(input logic [2:0] ch);
        cfg_rd_chan = ch;
        @(negedge clk);
        chk(cfg_rd_nib == exp_cfg[ch], "R10", "readback", cfg_rd_nib, exp_cfg[ch]);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < 8; i++) exp_cfg[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(spi_cs_n == 1'b1, "R1", "cs_n", spi_cs_n, 1);
        chk(spi_sclk == 1'b0, "R1", "sclk", spi_sclk, 0);
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(res_valid == 1'b0, "R1", "res_valid", res_valid, 0);
        for (int c = 0; c < 8; c++) check_readback(3'(c));

        // Directed: channel 2 differential setting, then conversion.
        run_txn(1'b0, 3'd2, 4'hC, 8'd0, 16'h0000, 1'b0);
        check_readback(3'd2);
        run_txn(1'b1, 3'd2, 4'h0, 8'd0, 16'h8001, 1'b0);
        run_txn(1'b1, 3'd7, 4'h0, 8'd3, 16'hFFFF, 1'b0);
        run_txn(1'b1, 3'd0, 4'h0, 8'd1, 16'h0000, 1'b0);
        // R9: requests held while busy are ignored
        run_txn(1'b1, 3'd1, 4'h0, 8'd2, 16'hA5C3, 1'b1);
        check_readback(3'd5);
        // R10: conversion leaves settings intact
        check_readback(3'd2);

        for (int t = 0; t < 30; t++) begin
            bit conv = 1'($urandom_range(0, 1));
            logic [2:0] ch = 3'($urandom_range(0, 7));
            logic [3:0] nib = 4'($urandom_range(1, 15));
            logic [7:0] hd = 8'($urandom_range(0, 3));
            logic [15:0] p = 16'($urandom);
            run_txn(conv, ch, nib, hd, p, 1'b0);
            if (!conv) check_readback(ch);
        end
        for (int c = 0; c < 8; c++) check_readback(3'(c));
        chk(!sclk_in_idle, "R7", "sclk high with cs_n high", sclk_in_idle, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule